// File: doc/BRIEF.md
# Conflict-Triggered Instruction Cache

This block is a small two-way set-associative instruction cache for a three-stage Harvard DSP core whose program-memory bus carries both instruction fetches and occasional data transfers. The cache sits idle during ordinary fetches. It is looked up only in a cycle where the instruction in execute uses the program bus for data while the fetch stage also wants that bus. The core raises a conflict strobe in such a cycle.

On a conflict hit, the cache supplies the fetched instruction word, so the data transfer and the fetch complete in the same cycle. On a conflict miss, the block raises a stall in that same cycle. The memory then delivers the instruction word, and that word is written into the cache at the clock edge that ends the cycle. A freeze input prevents any write or replacement. A flush input invalidates every entry. Three saturating counters record hits, misses and thrash events, where a thrash event is a fill that overwrites a valid entry.

Top module: `ccache_top`

## Requirements
- R1: After reset, every entry is invalid, so the first conflict cycle for any address misses with `stall_o` high. All three counters read zero.
- R2: In a cycle with `conflict_i` low, `hit_o` and `stall_o` are both low and the cache contents do not change. An address presented only on ordinary fetches still misses on its first conflict cycle.
- R3: When a conflict cycle misses, `stall_o` is high in that cycle and `fetch_word_i` is stored. A later conflict cycle at the same address then has `hit_o` high, `stall_o` low, and `hit_word_o` equal to the stored word. When there is no hit, `hit_word_o` is zero.
- R4: The set index is address bits [IDX_W-1:0], and the tag is the remaining upper bits. Two addresses with the same index and different tags can be held at the same time, one in each way.
- R5: A miss fills an invalid way of the indexed set before it evicts a valid one, taking way 0 first when both ways are invalid.
- R6: Each set has one LRU bit. A conflict hit marks the hit way as most recently used, and a fill marks the filled way as most recently used. When both ways are valid, a miss replaces the least recently used way.
- R7: While `freeze_i` is high, a conflict miss still stalls but stores nothing, so a repeat of that address misses again. Hits are still served. After `freeze_i` goes low, filling resumes.
- R8: A cycle with `flush_i` high invalidates all entries and clears all LRU bits, so every address misses afterwards.
- R9: `hit_cnt_o` counts conflict hits and `miss_cnt_o` counts conflict misses. Misses made while frozen are included.
- R10: `thrash_cnt_o` counts fills that overwrite a valid entry. A fill into an invalid way is not counted.
- R11: Each counter saturates at its all-ones value and holds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries and clear all LRU bits |
| conflict_i | input | 1 | Program-bus data access coincides with an instruction fetch |
| freeze_i | input | 1 | Block every write and replacement |
| fetch_addr_i | input | ADDR_W | Address of the instruction being fetched |
| fetch_word_i | input | DATA_W | Instruction word from memory, stored on a conflict miss |
| hit_o | output | 1 | Conflict cycle hit |
| stall_o | output | 1 | Conflict cycle miss; the core stalls for one cycle |
| hit_word_o | output | DATA_W | Cached instruction word on a hit, zero otherwise |
| hit_cnt_o | output | CNT_W | Saturating count of conflict hits |
| miss_cnt_o | output | CNT_W | Saturating count of conflict misses |
| thrash_cnt_o | output | CNT_W | Saturating count of fills that overwrite a valid entry |

## Verification
The bench uses a 16-bit address, a 32-bit word and 4 index bits, giving 16 sets. With these values, addresses 0x0004, 0x0014, 0x0024 and 0x0034 all fall into one set, which is enough to drive that set through free-way fills, LRU eviction, thrashing, freeze and flush. The counters are built only 4 bits wide, so saturation at 15 is reached with a short run of hits.

// File: rtl/ccache_pkg.sv
package ccache_pkg;

    // Per-cycle events reported by the tag store
    typedef struct packed {
        logic hit;
        logic miss;
        logic thrash;
    } cc_evt_t;

    localparam int unsigned CC_NUM_EVT = 3;

    // Write request towards the data array
    typedef struct packed {
        logic en;
        logic way;
    } cc_fill_t;

endpackage

// File: rtl/ccache_tags.sv
module ccache_tags
    import ccache_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              conflict_i,
    input  logic              freeze_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              hit_way_o,
    output logic [IDX_W-1:0]  idx_o,
    output cc_fill_t          fill_o,
    output cc_evt_t           evt_o
);
    localparam int unsigned SETS  = 1 << IDX_W;
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][1:0]             valid;
        logic [SETS-1:0][1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0]                  lru;   // way to replace next
    } tag_state_t;

    tag_state_t       st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag_in;
    logic [1:0]       way_match;
    logic             hit_any;
    logic             victim;

    assign idx    = addr_i[IDX_W-1:0];
    assign tag_in = addr_i[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_match[w] = st_q.valid[idx][w] && (st_q.tag[idx][w] == tag_in);
    end

    assign hit_any   = |way_match;
    assign hit_o     = conflict_i && hit_any;
    assign hit_way_o = way_match[1];
    assign idx_o     = idx;

    always_comb begin
        st_d   = st_q;
        fill_o = '0;
        evt_o  = '0;

        // invalid ways first, way 0 before way 1, then the LRU way
        if (!st_q.valid[idx][0])      victim = 1'b0;
        else if (!st_q.valid[idx][1]) victim = 1'b1;
        else                          victim = st_q.lru[idx];

        if (conflict_i) begin
            evt_o.hit  = hit_any;
            evt_o.miss = !hit_any;
        end

        if (conflict_i && !hit_any && !freeze_i && !flush_i) begin
            fill_o.en    = 1'b1;
            fill_o.way   = victim;
            evt_o.thrash = st_q.valid[idx][victim];
        end

        if (flush_i) begin
            st_d.valid = '0;
            st_d.lru   = '0;
        end else if (conflict_i && hit_any) begin
            st_d.lru[idx] = ~hit_way_o;
        end else if (fill_o.en) begin
            st_d.valid[idx][victim] = 1'b1;
            st_d.tag[idx][victim]   = tag_in;
            st_d.lru[idx]           = ~victim;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: contents stay put outside conflict and flush cycles
    p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!conflict_i && !flush_i) |=> ($stable(st_q.valid) && $stable(st_q.tag)));

    // R7: freeze blocks every write and replacement
    p_freeze_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_i && !flush_i) |=> ($stable(st_q.valid) && $stable(st_q.tag)));

    // R8: flush empties the whole store
    p_flush_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (st_q.valid == '0 && st_q.lru == '0));

    // R10: thrash only reported together with a fill
    p_thrash_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o.thrash |-> (fill_o.en && $countones(st_q.valid[idx]) == 2));

endmodule

// File: rtl/ccache_data.sv
module ccache_data
    import ccache_pkg::*;
#(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cc_fill_t          fill_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rway_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned SETS = 1 << IDX_W;

    logic [SETS-1:0][1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (fill_i.en) mem_d[idx_i][fill_i.way] = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[idx_i][rway_i];

    // R3: a fill lands in the selected slot
    p_fill_written_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_i.en |=> (mem_q[$past(idx_i)][$past(fill_i.way)] == $past(wdata_i)));

endmodule

// File: rtl/ccache_satcnt.sv
module ccache_satcnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && (st_q.cnt != '1)) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R11: a full counter stays full
    p_sat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o == '1) |=> (cnt_o == '1));

    // R9: counters never move backwards
    p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/ccache_top.sv
module ccache_top
    import ccache_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              conflict_i,
    input  logic              freeze_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [DATA_W-1:0] fetch_word_i,
    output logic              hit_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] hit_word_o,
    output logic [CNT_W-1:0]  hit_cnt_o,
    output logic [CNT_W-1:0]  miss_cnt_o,
    output logic [CNT_W-1:0]  thrash_cnt_o
);
    logic              hit;
    logic              hit_way;
    logic [IDX_W-1:0]  idx;
    cc_fill_t          fill;
    cc_evt_t           evt;
    logic [DATA_W-1:0] rdata;
    logic [CC_NUM_EVT-1:0]  evt_vec;
    logic [CNT_W-1:0]       cnt [CC_NUM_EVT];

    ccache_tags #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) tags_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush_i),
        .conflict_i (conflict_i),
        .freeze_i   (freeze_i),
        .addr_i     (fetch_addr_i),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .idx_o      (idx),
        .fill_o     (fill),
        .evt_o      (evt)
    );

    ccache_data #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fill_i  (fill),
        .idx_i   (idx),
        .wdata_i (fetch_word_i),
        .rway_i  (hit_way),
        .rdata_o (rdata)
    );

    assign evt_vec = evt;   // bit 2 hit, bit 1 miss, bit 0 thrash

    for (genvar e = 0; e < CC_NUM_EVT; e++) begin : g_cnt
        ccache_satcnt #(.CNT_W(CNT_W)) cnt_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .inc_i  (evt_vec[e]),
            .cnt_o  (cnt[e])
        );
    end

    assign hit_o        = hit;
    assign stall_o      = conflict_i && !hit;
    assign hit_word_o   = hit ? rdata : '0;
    assign hit_cnt_o    = cnt[2];
    assign miss_cnt_o   = cnt[1];
    assign thrash_cnt_o = cnt[0];

    // R3: never hit and stall together
    p_hit_xor_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && stall_o));

    // R2: no stall without a conflict
    p_stall_needs_conflict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> conflict_i);

    // R3: a filled address hits on an immediate repeat
    p_refill_hits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && !freeze_i && !flush_i) |=>
        (!(conflict_i && fetch_addr_i == $past(fetch_addr_i)) || hit_o));

    // R7: a frozen miss leaves the address uncached
    p_frozen_repeat_misses_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && freeze_i) |=>
        (!(conflict_i && fetch_addr_i == $past(fetch_addr_i)) || stall_o));

endmodule

// File: tb/ccache_top_tb_top.sv
module ccache_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              conflict = 1'b0;
    logic              freeze = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] word = '0;
    logic              hit, stall;
    logic [DATA_W-1:0] hit_word;
    logic [CNT_W-1:0]  hit_cnt, miss_cnt, thrash_cnt;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic              hit;
        logic              stall;
        logic [DATA_W-1:0] word;
        string             req;
    } exp_t;

    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .flush_i      (flush),
        .conflict_i   (conflict),
        .freeze_i     (freeze),
        .fetch_addr_i (addr),
        .fetch_word_i (word),
        .hit_o        (hit),
        .stall_o      (stall),
        .hit_word_o   (hit_word),
        .hit_cnt_o    (hit_cnt),
        .miss_cnt_o   (miss_cnt),
        .thrash_cnt_o (thrash_cnt)
    );

    localparam logic [DATA_W-1:0] WA = 32'hA1A1_0004;
    localparam logic [DATA_W-1:0] WB = 32'hB2B2_0014;
    localparam logic [DATA_W-1:0] WC = 32'hC3C3_0024;
    localparam logic [DATA_W-1:0] WD = 32'hD4D4_0034;
    localparam logic [DATA_W-1:0] WJ = 32'hDEAD_BEEF;

    // driver: one cycle of stimulus plus its expected result
    task automatic op(input logic [ADDR_W-1:0] a, input logic c, input logic [DATA_W-1:0] w,
                      input logic frz, input logic fl,
                      input logic eh, input logic es, input logic [DATA_W-1:0] ew, input string rq);
        exp_t e;
        @(negedge clk);
        addr = a; conflict = c; word = w; freeze = frz; flush = fl;
        e.hit = eh; e.stall = es; e.word = ew; e.req = rq;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string rq);
        op('0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, rq);
    endtask

    task automatic chk_cnt(input int eh, input int em, input int et, input string rq);
        #(CLK_PERIOD/4);
        checks++;
        if (hit_cnt != CNT_W'(eh) || miss_cnt != CNT_W'(em) || thrash_cnt != CNT_W'(et)) begin
            errors++;
            $display("FAIL %s counters hit/miss/thrash actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     rq, hit_cnt, miss_cnt, thrash_cnt, eh, em, et);
        end
    endtask

    // monitor: compare outputs mid-cycle against the queued item
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (hit !== e.hit || stall !== e.stall || hit_word !== e.word) begin
                    errors++;
                    $display("FAIL %s hit/stall/word actual %0b/%0b/%h expected %0b/%0b/%h",
                             e.req, hit, stall, hit_word, e.hit, e.stall, e.word);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        chk_cnt(0, 0, 0, "R1");

        op(16'h0004, 1, WA, 0, 0, 0, 1, '0, "R1");   // cold miss
        op(16'h0004, 0, WJ, 0, 0, 0, 0, '0, "R2");   // ordinary fetch: silent
        op(16'h0004, 1, WJ, 0, 0, 1, 0, WA, "R3");   // filled word returned
        op(16'h0005, 0, WJ, 0, 0, 0, 0, '0, "R2");   // ordinary fetch only
        op(16'h0005, 1, WJ, 0, 0, 0, 1, '0, "R2");   // so still a miss
        op(16'h0014, 1, WB, 0, 0, 0, 1, '0, "R4");   // same set, other tag
        op(16'h0004, 1, WJ, 0, 0, 1, 0, WA, "R4");
        op(16'h0014, 1, WJ, 0, 0, 1, 0, WB, "R5");   // went to the free way
        op(16'h0004, 1, WJ, 0, 0, 1, 0, WA, "R6");   // 0x0014 becomes LRU
        op(16'h0024, 1, WC, 0, 0, 0, 1, '0, "R6");   // evicts 0x0014
        op(16'h0004, 1, WJ, 0, 0, 1, 0, WA, "R6");   // survivor
        op(16'h0014, 1, WB, 0, 0, 0, 1, '0, "R6");   // evicted, refills over 0x0024

        op(16'h0034, 1, WD, 1, 0, 0, 1, '0, "R7");   // frozen miss
        op(16'h0034, 1, WD, 1, 0, 0, 1, '0, "R7");   // nothing stored
        op(16'h0004, 1, WJ, 1, 0, 1, 0, WA, "R7");   // hits still served
        op(16'h0014, 1, WJ, 1, 0, 1, 0, WB, "R7");   // 0x0004 now LRU
        op(16'h0034, 1, WD, 0, 0, 0, 1, '0, "R7");   // unfrozen: fills over 0x0004
        op(16'h0034, 1, WJ, 0, 0, 1, 0, WD, "R7");
        idle("R9");
        chk_cnt(8, 8, 3, "R9 R10");

        for (int i = 0; i < 10; i++) op(16'h0034, 1, WJ, 0, 0, 1, 0, WD, "R11");
        idle("R11");
        chk_cnt(15, 8, 3, "R11");

        op('0, 0, '0, 0, 1, 0, 0, '0, "R8");           // flush
        op(16'h0034, 1, WD, 0, 0, 0, 1, '0, "R8");   // gone after flush
        op(16'h0034, 1, WJ, 0, 0, 1, 0, WD, "R8");
        idle("R8");
        chk_cnt(15, 9, 3, "R8 R10");                  // fill into empty way: no thrash

        #(CLK_PERIOD);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule